// File: doc/BRIEF.md
# Retro Microcomputer Address Decoder with Terminal Port

This block sits on the memory bus of a small 8-bit processor with a 16-bit address. It splits the address space into sixteen 4 KiB banks by the top four address bits and serves each bus cycle from one of five places:

- a 4 KiB read/write RAM in the lowest bank;
- a computed 4 KiB read-only image in bank $E;
- a 256-byte monitor ROM that fills bank $F;
- a four-register terminal port in bank $D;
- a fixed $FF for everything else.

The terminal port turns keyboard and display traffic into a byte stream. A character arriving on the receive pair sets a "key ready" flag that software polls. A character written to the display data register leaves on the transmit pair under valid/ready flow control. Software sees a busy flag for as long as the link cannot take another character.

A bus cycle is one clock with `bus_strobe` high. Writes take effect at that edge. Read data is registered twice: once in the memories and the port, then in the output multiplexer. It appears on `rd_data` after the second rising edge and holds until the next read completes.

Top module: `rbd_top`

## Requirements
- R1: After reset, `rd_data` is $00, `tx_valid` is 0, keyboard control reads $00, and display control reads $00 while `tx_ready` is 1.
- R2: Bank $0 ($0000–$0FFF) is RAM indexed by address bits [11:0]. A byte written there reads back unchanged on `rd_data` after the second rising edge following the read strobe.
- R3: Bank $F is the monitor ROM, indexed only by address bits [7:0], so every page of $F000–$FFFF mirrors it. The byte at index i is i XOR $5A. Writes to the bank do not change what is read.
- R4: Bank $E is a read-only image whose byte at address a is a[7:0] XOR {a[11:8],a[11:8]} XOR $C3. Writes to the bank do not change what is read.
- R5: In bank $D, only address bits [7:0] select a port register, so every page mirrors the four registers. A cycle with `rx_valid` high stores `rx_data[6:0]` and sets bit 7 of keyboard control (offset $11); bits 6:0 of that register read 0. Reading keyboard control does not clear the flag.
- R6: Reading keyboard data (offset $10) returns {1, stored code[6:0]} and clears the keyboard flag, so the next read of keyboard control gives $00.
- R7: Bit 7 of display control (offset $13) reads 1 while `tx_valid` is 1 or `tx_ready` is 0, and 0 otherwise. Bits 6:0 read 0.
- R8: A write to display data (offset $12) when the link is not busy raises `tx_valid` at that edge with `tx_data` = {0, wdata[6:0]}. `tx_valid` and `tx_data` hold until an edge where `tx_ready` is 1, after which `tx_valid` is 0. A write to display data while the link is busy is dropped.
- R9: Reads return $FF from banks $1–$C and from offsets of bank $D other than $10–$13.
- R10: `rd_data` changes only as the completion of a read cycle and otherwise keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_strobe | input | 1 | Bus cycle valid in this clock |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rx_valid | input | 1 | Received character valid |
| rx_data | input | 8 | Received character |
| tx_valid | output | 1 | Character to transmit is valid |
| tx_data | output | 8 | Character to transmit (bit 7 always 0) |
| tx_ready | input | 1 | Link accepts the transmit character |

## Verification
Read results are due after the second rising edge following the read strobe. Each read task therefore drives the cycle at a falling edge, releases it at the next falling edge, and samples `rd_data` one falling edge later. Register effects of writes and received characters settle at the strobe's own edge. The bench samples `tx_valid` and `tx_data` at the falling edge straight after a display write, before the following edge can complete a transfer, and changes `tx_ready` only at falling edges. Keyboard flag changes are observed through a later read of keyboard control, which also carries the two-edge latency.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_RAM  = 3'd1,
    RG_EXT  = 3'd2,
    RG_MON  = 3'd3,
    RG_PORT = 3'd4
  } region_t;

  localparam logic [7:0] PORT_BASE = 8'h10;
  localparam logic [1:0] OFF_KDATA = 2'd0;
  localparam logic [1:0] OFF_KCTRL = 2'd1;
  localparam logic [1:0] OFF_DDATA = 2'd2;
  localparam logic [1:0] OFF_DCTRL = 2'd3;

  localparam logic [7:0] OPEN_BUS = 8'hFF;
  localparam logic [7:0] MON_KEY  = 8'h5A;
  localparam logic [7:0] EXT_KEY  = 8'hC3;
endpackage

// File: rtl/rbd_decode.sv
module rbd_decode
  import rbd_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int PAGE_W = 8,
  parameter logic [BANK_W-1:0] RAM_BANK  = 4'h0,
  parameter logic [BANK_W-1:0] PORT_BANK = 4'hD,
  parameter logic [BANK_W-1:0] EXT_BANK  = 4'hE,
  parameter logic [BANK_W-1:0] MON_BANK  = 4'hF,
  parameter bit EXT_EN = 1'b1
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [PAGE_W-1:0] page_off,
  output region_t           region,
  output logic [1:0]        port_off
);
  logic port_hit;

  assign port_hit = (page_off[PAGE_W-1:2] == PORT_BASE[PAGE_W-1:2]);
  assign port_off = page_off[1:0];

  always_comb begin
    region = RG_NONE;
    if (bank == RAM_BANK)                  region = RG_RAM;
    else if (bank == MON_BANK)             region = RG_MON;
    else if (EXT_EN && bank == EXT_BANK)   region = RG_EXT;
    else if (bank == PORT_BANK && port_hit) region = RG_PORT;
  end
endmodule

// File: rtl/rbd_ram.sv
module rbd_ram #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rbd_rom_image.sv
module rbd_rom_image
  import rbd_pkg::*;
#(
  parameter int KIND = 0,
  parameter int IW   = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] rdata
);
  generate
    if (KIND == 0) begin : g_monitor
      always_ff @(posedge clk) rdata <= idx[DW-1:0] ^ MON_KEY;
      if (IW > DW) begin : g_sink
        logic unused_hi;
        assign unused_hi = ^idx[IW-1:DW];
      end
    end else begin : g_ext
      logic [DW-1:0] fold;
      assign fold = {idx[IW-1 -: DW/2], idx[IW-1 -: DW/2]};
      always_ff @(posedge clk) rdata <= idx[DW-1:0] ^ fold ^ EXT_KEY;
    end
  endgenerate
endmodule

// File: rtl/rbd_term_port.sv
module rbd_term_port
  import rbd_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = DW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          rw,
  input  logic [1:0]    off,
  input  logic [DW-1:0] wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic [DW-1:0] rdata
);
  logic [CW-1:0] kbd_code;
  logic          kbd_rdy;
  logic          busy;
  logic          rd_kdata;
  logic          wr_ddata;
  logic          unused_msb;

  assign unused_msb = rx_data[DW-1] ^ wdata[DW-1];
  assign busy     = tx_valid | ~tx_ready;
  assign rd_kdata = sel &  rw & (off == OFF_KDATA);
  assign wr_ddata = sel & ~rw & (off == OFF_DDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      kbd_code <= '0;
      kbd_rdy  <= 1'b0;
    end else if (rx_valid) begin
      kbd_code <= rx_data[CW-1:0];
      kbd_rdy  <= 1'b1;
    end else if (rd_kdata) begin
      kbd_rdy  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      if (wr_ddata && !busy) begin
        tx_valid <= 1'b1;
        tx_data  <= {1'b0, wdata[CW-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && rw) begin
      unique case (off)
        OFF_KDATA: rdata <= {1'b1, kbd_code};
        OFF_KCTRL: rdata <= {kbd_rdy, {CW{1'b0}}};
        OFF_DDATA: rdata <= '0;
        OFF_DCTRL: rdata <= {busy, {CW{1'b0}}};
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rbd_top.sv
module rbd_top
  import rbd_pkg::*;
#(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 8,
  parameter int  BANK_W = 4,
  parameter int  PAGE_W = 8,
  parameter bit  EXT_EN = 1'b1,
  localparam int BANK_AW = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_strobe,
  input  logic              bus_rw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready
);
  region_t           region;
  region_t           region_q;
  logic [1:0]        port_off;
  logic              rd_req;
  logic              rd_pend;
  logic              ram_we;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] mon_q;
  logic [DATA_W-1:0] ext_q;
  logic [DATA_W-1:0] port_q;

  rbd_decode #(
    .BANK_W(BANK_W), .PAGE_W(PAGE_W), .EXT_EN(EXT_EN)
  ) dec_i (
    .bank     (bus_addr[ADDR_W-1 -: BANK_W]),
    .page_off (bus_addr[PAGE_W-1:0]),
    .region   (region),
    .port_off (port_off)
  );

  assign rd_req = bus_strobe &  bus_rw;
  assign ram_we = bus_strobe & ~bus_rw & (region == RG_RAM);

  rbd_ram #(.AW(BANK_AW), .DW(DATA_W)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .addr  (bus_addr[BANK_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  rbd_rom_image #(.KIND(0), .IW(PAGE_W), .DW(DATA_W)) mon_i (
    .clk   (clk),
    .idx   (bus_addr[PAGE_W-1:0]),
    .rdata (mon_q)
  );

  generate
    if (EXT_EN) begin : g_ext
      rbd_rom_image #(.KIND(1), .IW(BANK_AW), .DW(DATA_W)) ext_i (
        .clk   (clk),
        .idx   (bus_addr[BANK_AW-1:0]),
        .rdata (ext_q)
      );
    end else begin : g_no_ext
      assign ext_q = OPEN_BUS;
    end
  endgenerate

  rbd_term_port #(.DW(DATA_W)) port_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (bus_strobe && region == RG_PORT),
    .rw       (bus_rw),
    .off      (port_off),
    .wdata    (bus_wdata),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .rdata    (port_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      region_q <= RG_NONE;
    end else begin
      rd_pend  <= rd_req;
      if (rd_req) region_q <= region;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_pend) begin
      unique case (region_q)
        RG_RAM:  rd_data <= ram_q;
        RG_MON:  rd_data <= mon_q;
        RG_EXT:  rd_data <= ext_q;
        RG_PORT: rd_data <= port_q;
        default: rd_data <= OPEN_BUS;
      endcase
    end
  end
endmodule

// File: rtl/rbd_checks.sv
module rbd_checks (
  input logic        clk,
  input logic        rst,
  input logic        bus_strobe,
  input logic        bus_rw,
  input logic [15:0] bus_addr,
  input logic [7:0]  rd_data,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready
);
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_tx_done_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_valid);

  p_tx_ascii_r8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !tx_data[7]);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_strobe && bus_rw) |=> ##1 $stable(rd_data));

  p_open_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_rw && bus_addr[15:12] >= 4'h1 && bus_addr[15:12] <= 4'hC)
      |=> ##1 (rd_data == 8'hFF));

  p_monitor_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_rw && bus_addr[15:12] == 4'hF)
      |=> ##1 (rd_data == ($past(bus_addr[7:0], 2) ^ 8'h5A)));
endmodule

bind rbd_top rbd_checks chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_strobe (bus_strobe),
  .bus_rw     (bus_rw),
  .bus_addr   (bus_addr),
  .rd_data    (rd_data),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_ready   (tx_ready)
);

// File: tb/rbd_top_tb.sv
module rbd_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_strobe = 1'b0;
  logic        bus_rw = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rd_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbd_top dut_i (
    .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_strobe = 1'b1; bus_rw = 1'b0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_strobe = 1'b0; bus_rw = 1'b1;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_strobe = 1'b1; bus_rw = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_strobe = 1'b0;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic read_check(string req, logic [15:0] a, logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check8(req, d, exp);
  endtask

  function automatic logic [7:0] mon_exp(logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ext_exp(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hC3;
  endfunction

  task automatic t_reset;
    check8("R1 rd_data", rd_data, 8'h00);
    check8("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    read_check("R1 kbd ctrl", 16'hD011, 8'h00);
    read_check("R1 disp ctrl", 16'hD013, 8'h00);
  endtask

  task automatic t_ram;
    bus_write(16'h0000, 8'h11);
    bus_write(16'h0FFF, 8'hEE);
    bus_write(16'h0123, 8'h5C);
    read_check("R2 ram 0000", 16'h0000, 8'h11);
    read_check("R2 ram 0FFF", 16'h0FFF, 8'hEE);
    read_check("R2 ram 0123", 16'h0123, 8'h5C);
    bus_write(16'h1123, 8'h77);
    read_check("R2 bank1 no alias", 16'h0123, 8'h5C);
  endtask

  task automatic t_monitor;
    read_check("R3 mon FF00", 16'hFF00, mon_exp(16'hFF00));
    read_check("R3 mon FFFC", 16'hFFFC, mon_exp(16'hFFFC));
    read_check("R3 mon mirror F0FC", 16'hF0FC, mon_exp(16'hFFFC));
    bus_write(16'hFF20, 8'h00);
    read_check("R3 mon write ignored", 16'hFF20, mon_exp(16'hFF20));
  endtask

  task automatic t_ext;
    read_check("R4 ext E000", 16'hE000, ext_exp(16'hE000));
    read_check("R4 ext E9A7", 16'hE9A7, ext_exp(16'hE9A7));
    bus_write(16'hE9A7, ~ext_exp(16'hE9A7));
    read_check("R4 ext write ignored", 16'hE9A7, ext_exp(16'hE9A7));
  endtask

  task automatic t_open_bus;
    logic [7:0] last;
    read_check("R9 bank1", 16'h1000, 8'hFF);
    read_check("R9 bankC", 16'hCABC, 8'hFF);
    read_check("R9 bankD offset 14", 16'hD014, 8'hFF);
    read_check("R9 bankD offset 00", 16'hD200, 8'hFF);
    read_check("R10 setup", 16'h0000, 8'h11);
    bus_write(16'h0000, 8'h99);
    repeat (3) @(negedge clk);
    last = rd_data;
    check8("R10 rd_data held", last, 8'h11);
  endtask

  task automatic t_keyboard;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h4B;
    @(negedge clk);
    rx_valid = 1'b0;
    read_check("R5 kbd ready", 16'hD011, 8'h80);
    read_check("R5 kbd ready mirror", 16'hD711, 8'h80);
    read_check("R6 kbd data", 16'hD410, 8'hCB);
    read_check("R6 kbd cleared", 16'hD011, 8'h00);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hB0;
    @(negedge clk);
    rx_valid = 1'b0;
    read_check("R6 kbd data 7-bit", 16'hD010, 8'hB0);
  endtask

  task automatic t_display;
    tx_ready = 1'b0;
    read_check("R7 busy on ready low", 16'hD013, 8'h80);
    bus_write(16'hD012, 8'hC1);
    check8("R8 write dropped ready low", {7'b0, tx_valid}, 8'h00);
    tx_ready = 1'b1;
    read_check("R7 idle", 16'hD313, 8'h00);
    bus_write(16'hD312, 8'hC1);
    check8("R8 tx_valid raised", {7'b0, tx_valid}, 8'h01);
    check8("R8 tx_data", tx_data, 8'h41);
    tx_ready = 1'b0;
    read_check("R7 busy pending", 16'hD013, 8'h80);
    bus_write(16'hD012, 8'h42);
    check8("R8 busy write dropped", tx_data, 8'h41);
    check8("R8 held", {7'b0, tx_valid}, 8'h01);
    tx_ready = 1'b1;
    @(negedge clk);
    check8("R8 accepted", {7'b0, tx_valid}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ram();
    t_monitor();
    t_ext();
    t_open_bus();
    t_keyboard();
    t_display();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule